// File: doc/BRIEF.md
# Time-Multiplexed LMS Adaptive FIR Filter

This block is a 16-tap adaptive FIR filter that learns its own coefficients with the least-mean-squares rule. Each input sample is processed over eight clock cycles. Two multiply-accumulate lanes run side by side. In cycle t, one lane works on tap t and the other works on tap t+8. When the eighth cycle ends, the block forms the filter output and the error against a reference sample. It then presents both at its outputs together with a one-cycle valid pulse.

The coefficient update is folded into the same eight-cycle schedule. The error from the previous sample period is held in a register. While a tap is read in the current period, its correction (error times the matching older input, scaled by a power-of-two step size) is added first. The corrected value is then used in the product and written back. The step size is 2^-mu, with mu taken from a 4-bit input, so scaling is an arithmetic right shift and needs no multiplier. Coefficients are Q1.15 values and saturate at the ends of their range.

A typical use is system identification or echo cancelling. An upstream source strobes in an input sample and a desired sample. It waits for the valid pulse and then supplies the next pair.

Top module: `lms_tdm_filter`

## Requirements
- R1: Synchronous active-high reset clears all coefficients, the held error, the delay line, `y_out`, `e_out` and `out_valid`. The first sample after reset therefore gives y = 0 and e = d.
- R2: A sample is accepted on a clock edge where `x_valid` is high and the block is idle. `out_valid` then goes high for exactly one cycle, starting after the eighth following clock edge.
- R3: `x_valid` asserted while a sample is being processed is ignored. It does not shift the delay line and does not change the results.
- R4: `y_out` (21-bit signed) equals floor(sum over k=0..15 of c_k·x(n-k) / 2^15). Here x(n) is the newest sample, inputs are 16-bit signed, and the coefficients used are the ones already updated in this period.
- R5: `e_out` (22-bit signed) equals d(n) - y(n), with both values sign-extended.
- R6: Before use in period n, each coefficient becomes c_k + floor(e(n-1)·x(n-1-k) / 2^(15+mu)). Here e(n-1) is the error of the previous period, which is zero after reset.
- R7: `mu_shift` (0 to 15) selects the step size 2^-mu_shift. A larger value gives proportionally smaller corrections.
- R8: An updated coefficient outside [-32768, 32767] is clamped to the nearest bound.
- R9: When the desired signal comes from a fixed 16-tap system with Q1.15 taps and an input of broad spectrum, the error magnitude and the coefficient mismatch shrink to small residuals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | Input sample, signed |
| x_valid | input | 1 | Strobe that starts a sample period |
| d_in | input | 16 | Desired (reference) sample, signed, captured with x_in |
| mu_shift | input | 4 | Step-size exponent, step = 2^-mu_shift |
| y_out | output | 21 | Filter output, signed, registered |
| e_out | output | 22 | Error d - y, signed, registered |
| out_valid | output | 1 | One-cycle pulse marking new y_out and e_out |

## Verification
Coefficient saturation is the hardest case to reach from the ports. The coefficients are not visible, and clamping only happens after an error large enough, combined with a large old input, pushes a tap past full scale. The bench reaches it with a phase of full-range random input and desired samples at mu_shift = 0, where corrections reach thousands of LSBs per period. A bit-exact model tracks every tap and counts clamp events, so the bench confirms that clamping really occurred while y and e still match. A strobe raised in the middle of a busy period is also driven on purpose, to show that it leaves the delay line untouched.

// File: rtl/lms_pkg.sv
package lms_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} lms_state_e;

  // Accumulator width that cannot wrap for `taps` full-scale products.
  function automatic int acc_width(int dw, int cw, int taps);
    return dw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/lms_delay_line.sv
module lms_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 17
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift,
  input  logic [DW-1:0]         din,
  output logic [DEPTH*DW-1:0]   taps
);

  // Tap 0 sits in the least significant slice; a shift pushes every tap one slot up.
  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (shift) begin
      taps <= {taps[(DEPTH-1)*DW-1:0], din};
    end
  end

endmodule

// File: rtl/lms_lane.sv
module lms_lane #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TM   = 8,
  parameter int EW   = 22,
  parameter int MUW  = 4,
  parameter int ACCW = 36,
  localparam int IW  = $clog2(TM)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   run,
  input  logic [IW-1:0]          idx,
  input  logic signed [DW-1:0]   x_cur,
  input  logic signed [DW-1:0]   x_old,
  input  logic signed [EW-1:0]   e_prev,
  input  logic [MUW-1:0]         mu,
  output logic signed [ACCW-1:0] acc_nxt
);

  localparam int PW = EW + DW;
  localparam int UW = PW + 1;
  localparam int MW = DW + CW;
  localparam logic signed [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] CMIN = ~CMAX;
  localparam logic signed [UW-1:0] SMAX = {{(UW-CW){1'b0}}, CMAX};
  localparam logic signed [UW-1:0] SMIN = ~SMAX;

  logic signed [CW-1:0]   bank [TM];
  logic signed [CW-1:0]   c_rd;
  logic signed [CW-1:0]   c_new;
  logic signed [PW-1:0]   grad;
  logic signed [PW-1:0]   step;
  logic signed [UW-1:0]   c_sum;
  logic signed [MW-1:0]   mult;
  logic signed [ACCW-1:0] acc_q;

  assign c_rd  = bank[idx];
  assign grad  = e_prev * x_old;
  assign step  = grad >>> (DW - 1 + int'(mu));
  assign c_sum = c_rd + step;

  always_comb begin
    if (c_sum > SMAX) begin
      c_new = CMAX;
    end else if (c_sum < SMIN) begin
      c_new = CMIN;
    end else begin
      c_new = $signed(c_sum[CW-1:0]);
    end
  end

  assign mult    = x_cur * c_new;
  assign acc_nxt = acc_q + mult;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      for (int i = 0; i < TM; i++) begin
        bank[i] <= '0;
      end
    end else if (clear) begin
      acc_q <= '0;
    end else if (run) begin
      acc_q     <= acc_nxt;
      bank[idx] <= c_new;
    end
  end

  // R6: with no error held from the last period, a tap must not move.
  a_r6_zero_error_keeps: assert property (@(posedge clk) disable iff (rst)
    (run && e_prev == '0) |-> (c_new == c_rd));

endmodule

// File: rtl/lms_tdm_filter.sv
module lms_tdm_filter #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 16,
  parameter int TM   = 8,
  parameter int MUW  = 4,
  localparam int ACCW = lms_pkg::acc_width(DW, CW, TAPS),
  localparam int YW   = ACCW - CW + 1,
  localparam int EW   = YW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       x_in,
  input  logic                x_valid,
  input  logic [DW-1:0]       d_in,
  input  logic [MUW-1:0]      mu_shift,
  output logic [YW-1:0]       y_out,
  output logic [EW-1:0]       e_out,
  output logic                out_valid
);

  localparam int LANES = TAPS / TM;
  localparam int IW    = $clog2(TM);
  localparam int DEPTH = TAPS + 1;

  lms_pkg::lms_state_e state;
  logic [IW-1:0]          cnt;
  logic signed [DW-1:0]   d_hold;
  logic signed [EW-1:0]   e_prev;
  logic                   start;
  logic                   running;
  logic                   last;
  logic [DEPTH*DW-1:0]    dl_flat;
  logic signed [ACCW-1:0] lane_acc [LANES];
  logic signed [ACCW-1:0] total;
  logic signed [YW-1:0]   y_w;
  logic signed [EW-1:0]   e_w;

  assign start   = (state == lms_pkg::ST_IDLE) && x_valid;
  assign running = (state == lms_pkg::ST_RUN);
  assign last    = running && (cnt == IW'(TM - 1));

  lms_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_line (
    .clk   (clk),
    .rst   (rst),
    .shift (start),
    .din   (x_in),
    .taps  (dl_flat)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [DW-1:0] x_cur;
    logic signed [DW-1:0] x_old;
    assign x_cur = $signed(dl_flat[(l*TM + int'(cnt))*DW +: DW]);
    assign x_old = $signed(dl_flat[(l*TM + int'(cnt) + 1)*DW +: DW]);

    lms_lane #(
      .DW(DW), .CW(CW), .TM(TM), .EW(EW), .MUW(MUW), .ACCW(ACCW)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .clear   (start),
      .run     (running),
      .idx     (cnt),
      .x_cur   (x_cur),
      .x_old   (x_old),
      .e_prev  (e_prev),
      .mu      (mu_shift),
      .acc_nxt (lane_acc[l])
    );
  end

  always_comb begin
    total = '0;
    for (int l = 0; l < LANES; l++) begin
      total = total + lane_acc[l];
    end
  end

  assign y_w = YW'(total >>> (CW - 1));
  assign e_w = d_hold - y_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= lms_pkg::ST_IDLE;
      cnt       <= '0;
      d_hold    <= '0;
      e_prev    <= '0;
      y_out     <= '0;
      e_out     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        d_hold <= $signed(d_in);
        cnt    <= '0;
        state  <= lms_pkg::ST_RUN;
      end else if (running) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          state     <= lms_pkg::ST_IDLE;
          y_out     <= y_w;
          e_out     <= e_w;
          e_prev    <= e_w;
          out_valid <= 1'b1;
        end
      end
    end
  end

  // R2: results are flagged for a single cycle only.
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2: a result is only flagged right after a busy period.
  a_r2_valid_after_run: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(running));

  // R2: the tap counter rests at zero between sample periods.
  a_r2_idle_count: assert property (@(posedge clk) disable iff (rst)
    (state == lms_pkg::ST_IDLE) |-> (cnt == '0));

  // R3: a strobe during a busy period leaves the newest tap alone.
  a_r3_busy_holds_line: assert property (@(posedge clk) disable iff (rst)
    (running && x_valid) |=> $stable(dl_flat[DW-1:0]));

endmodule

// File: tb/test_lms_tdm_filter.sv
module test_lms_tdm_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x_in = '0;
  logic        x_valid = 1'b0;
  logic [15:0] d_in = '0;
  logic [3:0]  mu_shift = '0;
  logic [20:0] y_out;
  logic [21:0] e_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  longint xh [0:16];
  longint cm [0:15];
  longint ep;
  longint ph [0:15];
  longint hx [0:15];
  int     nsat;

  always #4 clk = ~clk;

  lms_tdm_filter i_lms_tdm_filter (
    .clk(clk), .rst(rst), .x_in(x_in), .x_valid(x_valid), .d_in(d_in),
    .mu_shift(mu_shift), .y_out(y_out), .e_out(e_out), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i <= 16; i++) xh[i] = 0;
    for (int i = 0; i < 16; i++) cm[i] = 0;
    ep = 0;
  endtask

  task automatic model_step(input longint x, input longint d, input int mu,
                            output longint y, output longint e);
    longint sum;
    longint c;
    for (int i = 16; i > 0; i--) xh[i] = xh[i-1];
    xh[0] = x;
    sum = 0;
    for (int k = 0; k < 16; k++) begin
      c = cm[k] + ((ep * xh[k+1]) >>> (15 + mu));
      if (c > 32767) begin c = 32767; nsat++; end
      if (c < -32768) begin c = -32768; nsat++; end
      cm[k] = c;
      sum += xh[k] * c;
    end
    y = sum >>> 15;
    e = d - y;
    ep = e;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    x_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R1: cleared outputs during reset
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    check(y_out == '0, "R1 y", longint'($signed(y_out)), 0);
    check(e_out == '0, "R1 e", longint'($signed(e_out)), 0);
    rst = 1'b0;
    model_reset();
  endtask

  // Drives one sample, optionally raises a stray strobe mid-period, checks y and e.
  task automatic do_sample(input longint x, input longint d, input bit junk,
                           input string tag, output longint e_got);
    longint ye, ee;
    int lat;
    @(negedge clk);
    x_in = 16'(x);
    d_in = 16'(d);
    x_valid = 1'b1;
    @(negedge clk);
    x_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
      if (junk && lat == 3) begin
        x_valid = 1'b1;
        x_in = 16'($urandom);
        d_in = 16'($urandom);
      end else if (junk && lat == 4) begin
        x_valid = 1'b0;
      end
    end
    model_step(x, d, int'(mu_shift), ye, ee);
    check(lat == 9, junk ? "R3 latency" : "R2 latency", lat, 9);
    check(longint'($signed(y_out)) == ye, tag, longint'($signed(y_out)), ye);
    check(longint'($signed(e_out)) == ee, "R5 error", longint'($signed(e_out)), ee);
    e_got = longint'($signed(e_out));
    @(negedge clk);
    check(out_valid == 1'b0, "R2 pulse", longint'(out_valid), 0);
  endtask

  function automatic longint rnd_range(input int half);
    return longint'($urandom_range(2 * half)) - longint'(half);
  endfunction

  initial begin
    longint eg, dd, maxe, dev;
    void'($urandom(32'd20240611));
    nsat = 0;
    model_reset();
    do_reset();

    // R1: first sample after reset sees zero taps
    mu_shift = 4'd4;
    do_sample(1000, 500, 1'b0, "R4 first", eg);
    check(eg == 500, "R1 e=d", eg, 500);
    do_sample(-2000, 300, 1'b0, "R6 second", eg);

    // R4, R6: random stream at moderate step
    for (int i = 0; i < 30; i++)
      do_sample(rnd_range(12000), rnd_range(12000), 1'b0, "R4 random", eg);

    // R3: stray strobes while busy
    for (int i = 0; i < 6; i++)
      do_sample(rnd_range(12000), rnd_range(12000), 1'b1, "R3 ignored", eg);

    // R7: step-size corner values
    mu_shift = 4'd15;
    for (int i = 0; i < 10; i++)
      do_sample(rnd_range(32000), rnd_range(32000), 1'b0, "R7 mu=15", eg);
    mu_shift = 4'd9;
    for (int i = 0; i < 10; i++)
      do_sample(rnd_range(32000), rnd_range(32000), 1'b0, "R7 mu=9", eg);

    // R8: full-range stimulus at the largest step drives taps to the rails
    mu_shift = 4'd0;
    nsat = 0;
    do_sample(-32768, 32767, 1'b0, "R8 extreme", eg);
    do_sample(32767, -32768, 1'b0, "R8 extreme", eg);
    for (int i = 0; i < 30; i++)
      do_sample(longint'($signed(16'($urandom))), longint'($signed(16'($urandom))),
                1'b0, "R8 saturate", eg);
    check(nsat > 0, "R8 clamp reached", nsat, 1);

    // R9: identify a fixed 16-tap system
    do_reset();
    for (int k = 0; k < 16; k++) begin
      ph[k] = ((k % 2) == 1 ? -1 : 1) * (3000 - 150 * k);
      hx[k] = 0;
    end
    mu_shift = 4'd1;
    maxe = 0;
    for (int n = 0; n < 800; n++) begin
      longint xv, acc;
      xv = rnd_range(16000);
      for (int k = 15; k > 0; k--) hx[k] = hx[k-1];
      hx[0] = xv;
      acc = 0;
      for (int k = 0; k < 16; k++) acc += ph[k] * hx[k];
      dd = acc >>> 15;
      do_sample(xv, dd, 1'b0, "R9 track", eg);
      if (n >= 750 && (eg > maxe || -eg > maxe)) maxe = (eg < 0) ? -eg : eg;
    end
    check(maxe <= 400, "R9 residual error", maxe, 400);
    dev = 0;
    for (int k = 0; k < 16; k++) begin
      longint dk;
      dk = cm[k] - ph[k];
      if (dk < 0) dk = -dk;
      if (dk > dev) dev = dk;
    end
    check(dev <= 200, "R9 tap mismatch", dev, 200);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule